// File: doc/BRIEF.md
# Key-Protected Oscillator Control Register Gate

This block guards the two bytes of an oscillator control register against stray software writes. Each byte has its own two-value key. A real write to a byte lands only if it comes in the bus cycle right after the two key values were written to that same byte on back-to-back cycles. Once that single write is accepted, the byte locks again at once. Key writes never change the stored contents.

The block sits on a plain byte-wide write port: a strobe, a one-bit byte select and eight data bits. It drives one write-enable pulse per byte, which marks the cycle a write is accepted. It also drives the two stored bytes. Some bit positions in the stored bytes are status fields fed by the clock-switching logic. Those positions follow their inputs one cycle later, and software can never write them, even when the byte is unlocked.

Top module: `keyreg_gate`

## Requirements
- R1: While reset is held, both stored bytes read 0x00 and both write-enable bits are 0.
- R2: Writing 0x78 and then 0x9A to the upper byte (select = 1) on consecutive cycles opens it. A write to that byte in the very next cycle raises `byte_we_o[1]` during that cycle. After the edge, upper bits [2:0] (the new-source selection) hold the written bits [2:0].
- R3: Writing 0x46 and then 0x57 to the lower byte (select = 0) on consecutive cycles opens it. A write to that byte in the very next cycle raises `byte_we_o[0]` during that cycle. After the edge, lower bits 7, 6, 4, 2, 1 and 0 (bit 0 being the switch enable) hold the written values.
- R4: A write to a locked byte raises no write enable and leaves the byte unchanged.
- R5: A cycle without a write strobe, placed between the two keys or between the second key and the data write, relocks the byte.
- R6: A write to the other byte at any point in a byte's key sequence relocks that byte.
- R7: A key value that does not match relocks the byte. This includes writing the first key twice.
- R8: After one accepted write the byte is locked, so a further write in the next cycle is ignored.
- R9: Upper bits [6:4] show `cur_src_i` one cycle later and are never written. Upper bits 7 and 3 always read 0.
- R10: Lower bit 5 shows `pll_lock_i` and lower bit 3 shows `clk_fail_i`, each one cycle later. Values written to those two positions are discarded.
- R11: Key writes themselves raise no write enable and do not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 1 | Byte select: 1 = upper byte, 0 = lower byte |
| bus_wdata | input | 8 | Write data |
| cur_src_i | input | 3 | Current-source status from the clock-switching logic |
| pll_lock_i | input | 1 | PLL lock status |
| clk_fail_i | input | 1 | Clock-fail status |
| byte_we_o | output | 2 | Accepted-write pulse per byte (bit 1 upper, bit 0 lower) |
| ctl_hi_o | output | 8 | Stored upper byte |
| ctl_lo_o | output | 8 | Stored lower byte |

## Verification
An accepted software write to the lower byte can land on the same edge as a change on a status input that the same register captures. The bench provokes this by flipping `pll_lock_i` in the cycle of the unlocked data write, with that data setting every bit. It then requires that the writable positions take the data while bit 5 takes the new status and bit 3 takes the status input, not the written ones. A second overlap is a key sequence on one byte interleaved with writes to the other byte. Here the bench requires that the foreign write relocks the first byte.

// File: rtl/keyreg_pkg.sv
// Package: shared types for the key-protected control register gate.
// Assumes: two bytes, each with its own three-state lock sequence.
package keyreg_pkg;
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,  // locked, waiting for first key
        LK_HALF = 2'd1,  // first key seen last cycle
        LK_OPEN = 2'd2   // both keys seen; one write allowed now
    } lock_st_t;

    localparam int NUM_BYTES = 2;
endpackage

// File: rtl/keylock_fsm.sv
// Module: keylock_fsm
// Tracks the two-value key sequence for one register byte and grants
// exactly one write in the cycle after the second key.
// Assumes: 'hit' is high only for a strobed write aimed at this byte;
// any other cycle breaks the sequence.
module keylock_fsm
    import keyreg_pkg::*;
#(
    parameter int              DW    = 8,
    parameter logic [DW-1:0]   KEY_A = '0,
    parameter logic [DW-1:0]   KEY_B = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] data,
    output logic          grant
);
    lock_st_t state, state_nx;

    // Next-state: advance only on a matching key aimed at this byte.
    always_comb begin
        state_nx = LK_IDLE;
        case (state)
            LK_IDLE: state_nx = (hit && data == KEY_A) ? LK_HALF : LK_IDLE;
            LK_HALF: state_nx = (hit && data == KEY_B) ? LK_OPEN : LK_IDLE;
            LK_OPEN: state_nx = LK_IDLE;
            default: state_nx = LK_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_IDLE;
        else        state <= state_nx;
    end

    // A write is granted only while open and aimed at this byte.
    assign grant = (state == LK_OPEN) && hit;

    // R8: a grant is never followed directly by another grant
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);
    // R5: a cycle with no write to this byte means no grant next cycle
    a_r5_gap_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !grant);
    // R7: a grant needs the second key on the previous cycle
    a_r7_key_b_before: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(hit && data == KEY_B));
endmodule

// File: rtl/byte_store.sv
// Module: byte_store
// Holds one register byte. Writable positions load on a granted write.
// Status positions follow their inputs each cycle. All else reads 0.
// Assumes: WR_MASK and RO_MASK do not overlap.
module byte_store #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] WR_MASK = '0,
    parameter logic [DW-1:0] RO_MASK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ro_val,
    output logic [DW-1:0] q
);
    logic [DW-1:0] sw_part;

    // Software field: new data when granted, otherwise held.
    always_comb sw_part = we ? (wdata & WR_MASK) : (q & WR_MASK);

    // Register: merge the software field with the sampled status.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= sw_part | (ro_val & RO_MASK);
    end

    // R4: without a grant the writable field holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((q & WR_MASK) == $past(q & WR_MASK)));
    // R3: a grant lands the written bits in the writable field
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q & WR_MASK) == ($past(wdata) & WR_MASK)));
    // R10: status positions follow their inputs one cycle later
    a_r10_status_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & RO_MASK) == ($past(ro_val) & RO_MASK)));
endmodule

// File: rtl/keyreg_gate.sv
// Module: keyreg_gate (top)
// Key-protected two-byte oscillator control register. Each byte has a
// lock FSM and a store. Select 1 addresses the upper byte.
// Assumes: one bus write per cycle, and status inputs synchronous to clk.
module keyreg_gate
    import keyreg_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            SEL_W      = 3,
    parameter int            CUR_LSB    = 4,
    parameter int            LOCK_BIT   = 5,
    parameter int            FAIL_BIT   = 3,
    parameter logic [DW-1:0] HI_KEY_A   = 8'h78,
    parameter logic [DW-1:0] HI_KEY_B   = 8'h9A,
    parameter logic [DW-1:0] LO_KEY_A   = 8'h46,
    parameter logic [DW-1:0] LO_KEY_B   = 8'h57,
    parameter logic [DW-1:0] HI_WR_MASK = 8'h07,
    parameter logic [DW-1:0] LO_WR_MASK = 8'hD7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic                 bus_sel,
    input  logic [DW-1:0]        bus_wdata,
    input  logic [SEL_W-1:0]     cur_src_i,
    input  logic                 pll_lock_i,
    input  logic                 clk_fail_i,
    output logic [NUM_BYTES-1:0] byte_we_o,
    output logic [DW-1:0]        ctl_hi_o,
    output logic [DW-1:0]        ctl_lo_o
);
    localparam logic [DW-1:0] HI_RO_MASK = DW'(((1 << SEL_W) - 1) << CUR_LSB);
    localparam logic [DW-1:0] LO_RO_MASK = DW'((1 << LOCK_BIT) | (1 << FAIL_BIT));

    logic [DW-1:0] ro_val [NUM_BYTES];
    logic [DW-1:0] q_arr  [NUM_BYTES];

    // Place the status inputs at their bit positions in each byte.
    always_comb begin
        ro_val[1] = '0;
        ro_val[1][CUR_LSB +: SEL_W] = cur_src_i;
        ro_val[0] = '0;
        ro_val[0][LOCK_BIT] = pll_lock_i;
        ro_val[0][FAIL_BIT] = clk_fail_i;
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam logic          SEL   = (i == 1);
        localparam logic [DW-1:0] KA    = (i == 1) ? HI_KEY_A   : LO_KEY_A;
        localparam logic [DW-1:0] KB    = (i == 1) ? HI_KEY_B   : LO_KEY_B;
        localparam logic [DW-1:0] WRM   = (i == 1) ? HI_WR_MASK : LO_WR_MASK;
        localparam logic [DW-1:0] ROM   = (i == 1) ? HI_RO_MASK : LO_RO_MASK;

        logic hit;
        // Decode a strobed write aimed at this byte.
        always_comb hit = bus_we && (bus_sel == SEL);

        keylock_fsm #(.DW(DW), .KEY_A(KA), .KEY_B(KB)) u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit),
            .data  (bus_wdata),
            .grant (byte_we_o[i])
        );

        byte_store #(.DW(DW), .WR_MASK(WRM), .RO_MASK(ROM)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (byte_we_o[i]),
            .wdata  (bus_wdata),
            .ro_val (ro_val[i]),
            .q      (q_arr[i])
        );
    end

    assign ctl_hi_o = q_arr[1];
    assign ctl_lo_o = q_arr[0];

    // R6: at most one byte accepts a write in any cycle
    a_r6_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_we_o));
    // R2: an upper-byte grant needs a strobed write to the upper byte
    a_r2_hi_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we_o[1] |-> (bus_we && bus_sel));
    // R9: reserved upper bits stay clear
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hi_o & ~(HI_WR_MASK | HI_RO_MASK)) == '0);
endmodule

// File: tb/sim_keyreg_gate.sv
// Scoreboard bench: the driver pushes an expected item for each cycle it
// drives, and the monitor pops it and compares against the outputs.
module sim_keyreg_gate;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_we;
    logic       bus_sel;
    logic [7:0] bus_wdata;
    logic [2:0] cur_src_i;
    logic       pll_lock_i;
    logic       clk_fail_i;
    logic [1:0] byte_we_o;
    logic [7:0] ctl_hi_o;
    logic [7:0] ctl_lo_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] we;
        logic [7:0] hi;
        logic [7:0] lo;
        string      req;
    } item_t;
    item_t sb[$];

    logic [7:0] m_hi = 8'h00;   // expected writable field, upper
    logic [7:0] m_lo = 8'h00;   // expected writable field, lower
    logic [2:0] st_cur  = 3'd0;
    logic       st_lock = 1'b0;
    logic       st_fail = 1'b0;

    always #2.5 clk = ~clk;     // 200 MHz

    keyreg_gate u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .cur_src_i(cur_src_i), .pll_lock_i(pll_lock_i),
        .clk_fail_i(clk_fail_i), .byte_we_o(byte_we_o),
        .ctl_hi_o(ctl_hi_o), .ctl_lo_o(ctl_lo_o)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one bus cycle and push what it must produce.
    task automatic cyc(input bit w, input bit sel, input logic [7:0] d,
                       input logic [1:0] exp_we, input string req);
        item_t it;
        @(negedge clk);
        bus_we = w; bus_sel = sel; bus_wdata = d;
        cur_src_i = st_cur; pll_lock_i = st_lock; clk_fail_i = st_fail;
        if (exp_we[1]) m_hi = (m_hi & ~8'h07) | (d & 8'h07);
        if (exp_we[0]) m_lo = (m_lo & ~8'hD7) | (d & 8'hD7);
        it.we  = exp_we;
        it.hi  = m_hi | {1'b0, st_cur, 4'b0};
        it.lo  = m_lo | {2'b0, st_lock, 1'b0, st_fail, 3'b0};
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare the write enables before the edge and the bytes after it.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check8(it.req, "byte_we", {6'b0, byte_we_o}, {6'b0, it.we});
                @(posedge clk);
                #1;
                check8(it.req, "ctl_hi", ctl_hi_o, it.hi);
                check8(it.req, "ctl_lo", ctl_lo_o, it.lo);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00;
        cur_src_i = 3'd0; pll_lock_i = 1'b0; clk_fail_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        check8("R1", "byte_we", {6'b0, byte_we_o}, 8'h00);
        check8("R1", "ctl_hi", ctl_hi_o, 8'h00);
        check8("R1", "ctl_lo", ctl_lo_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and R11: upper unlock, then the data write lands in bits 2:0
        cyc(1, 1, 8'h78, 2'b00, "R11");
        cyc(1, 1, 8'h9A, 2'b00, "R11");
        cyc(1, 1, 8'hFD, 2'b10, "R2");
        // R8: relocked immediately
        cyc(1, 1, 8'h02, 2'b00, "R8");

        // R3 and R10: lower unlock; the data sets every bit while lock flips
        cyc(1, 0, 8'h46, 2'b00, "R11");
        cyc(1, 0, 8'h57, 2'b00, "R11");
        st_lock = 1'b1;
        cyc(1, 0, 8'hFF, 2'b01, "R10");
        cyc(1, 0, 8'h00, 2'b00, "R8");

        // R4: write without keys
        cyc(1, 0, 8'h00, 2'b00, "R4");
        cyc(1, 1, 8'h00, 2'b00, "R4");

        // R5: idle between keys, then idle between key and data
        cyc(1, 0, 8'h46, 2'b00, "R5");
        cyc(0, 0, 8'h00, 2'b00, "R5");
        cyc(1, 0, 8'h57, 2'b00, "R5");
        cyc(1, 0, 8'h00, 2'b00, "R5");
        cyc(1, 1, 8'h78, 2'b00, "R5");
        cyc(1, 1, 8'h9A, 2'b00, "R5");
        cyc(0, 1, 8'h00, 2'b00, "R5");
        cyc(1, 1, 8'h00, 2'b00, "R5");

        // R6: key aimed at the wrong byte, and interleaved writes
        cyc(1, 1, 8'h78, 2'b00, "R6");
        cyc(1, 0, 8'h9A, 2'b00, "R6");
        cyc(1, 1, 8'h00, 2'b00, "R6");
        cyc(1, 0, 8'h46, 2'b00, "R6");
        cyc(1, 1, 8'h78, 2'b00, "R6");
        cyc(1, 0, 8'h57, 2'b00, "R6");
        cyc(1, 0, 8'h00, 2'b00, "R6");

        // R7: wrong second key, and the first key written twice
        cyc(1, 1, 8'h78, 2'b00, "R7");
        cyc(1, 1, 8'h9B, 2'b00, "R7");
        cyc(1, 1, 8'h00, 2'b00, "R7");
        cyc(1, 1, 8'h78, 2'b00, "R7");
        cyc(1, 1, 8'h78, 2'b00, "R7");
        cyc(1, 1, 8'h9A, 2'b00, "R7");
        cyc(1, 1, 8'h00, 2'b00, "R7");

        // R9: current-source mirror; an unlocked all-ones write reaches only bits 2:0
        st_cur = 3'b101;
        cyc(0, 0, 8'h00, 2'b00, "R9");
        cyc(1, 1, 8'h78, 2'b00, "R9");
        cyc(1, 1, 8'h9A, 2'b00, "R9");
        cyc(1, 1, 8'hFF, 2'b10, "R9");

        // R10: fail status follows, and an unlocked write clears the lower field
        st_fail = 1'b1;
        st_lock = 1'b0;
        cyc(1, 0, 8'h46, 2'b00, "R10");
        cyc(1, 0, 8'h57, 2'b00, "R10");
        cyc(1, 0, 8'h28, 2'b01, "R10");
        cyc(0, 0, 8'h00, 2'b00, "R10");

        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule